// File: doc/BRIEF.md
# Low-Power Mode and Wakeup Sequencer

This block decides which clock domains of a small microcontroller run at any moment. Software requests a low-power state with a single write strobe that carries two request bits. The deep-sleep request stops every clock, the oscillator included. The light-sleep request keeps the oscillator, the instruction-cycle prescaler and the base timer running and gates off the CPU core and all other peripherals. Register, RAM and I/O contents are not touched, because the block only removes clock enables.

In deep sleep, a wakeup event does not hand the clocks straight back to the core. It first turns the oscillator back on. A down-counter, loaded with a fixed startup count and stepped by the instruction-cycle tick (the oscillator clock divided by a fixed ratio), then gives the oscillator time to settle. Only when that count runs out are the core and timer clocks enabled again. A wakeup in light sleep returns to normal running in one cycle. An asynchronous reset brings the block back to normal running at once, with no startup wait. A build-time option removes deep sleep altogether.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in the running state: `core_clk_en`, `osc_en` and `t0_clk_en` are 1, and `halt_flag` and `idle_flag` are 0.
- R2: In the running state, `tc_tick` is high for one cycle out of every DIV_RATIO cycles (default 10).
- R3: A write (`ctl_we`=1) with `ctl_halt`=1 in the running state enters deep sleep on the next cycle. In deep sleep `halt_flag`=1 and `osc_en`, `core_clk_en`, `t0_clk_en` and `tc_tick` are all 0.
- R4: A write with `ctl_idle`=1 and `ctl_halt`=0 in the running state enters light sleep on the next cycle. In light sleep `idle_flag`=1, `core_clk_en`=0, `osc_en`=1, `t0_clk_en`=1, and `tc_tick` keeps pulsing once every DIV_RATIO cycles.
- R5: When `ctl_halt` and `ctl_idle` are both 1 in one write, deep sleep is entered.
- R6: `wake`=1 in deep sleep moves the block to warm-up on the next cycle. In warm-up `osc_en`=1, `halt_flag`=1, and `core_clk_en`=0 and `t0_clk_en`=0. Counting from the edge that samples `wake`, `core_clk_en` first reads 1 after exactly STARTUP_TICKS×DIV_RATIO edges (2560 by default), and `halt_flag` clears at the same point.
- R7: In warm-up the prescaler starts from zero. The first `tc_tick` is seen after DIV_RATIO−1 edges, counting from the edge that samples `wake`.
- R8: `wake`=1 in light sleep returns the block to the running state on the next cycle, with `idle_flag`=0.
- R9: `wake` in the running state has no effect. So do writes with both request bits 0, and any write made in light sleep, deep sleep or warm-up.
- R10: With HALT_ENABLE=0, a deep-sleep request has no effect: `halt_flag` stays 0 and `core_clk_en` stays 1. A write carrying both bits then enters light sleep.
- R11: Asserting reset in deep sleep or warm-up restores the running state at once, with no startup wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Mode-request write strobe |
| ctl_halt | input | 1 | Deep-sleep request bit, taken when ctl_we=1 |
| ctl_idle | input | 1 | Light-sleep request bit, taken when ctl_we=1 |
| wake | input | 1 | Wakeup event, synchronous to clk |
| osc_en | output | 1 | Oscillator domain enable |
| core_clk_en | output | 1 | Clock enable for the core and general peripherals |
| t0_clk_en | output | 1 | Clock enable for the base timer |
| tc_tick | output | 1 | Instruction-cycle tick, one clk cycle wide |
| halt_flag | output | 1 | Deep sleep or warm-up in progress |
| idle_flag | output | 1 | Light sleep in progress |

## Verification
A table of per-cycle vectors drives the mode requests: a plain wake, an empty write, a light-sleep write, a deep-sleep write made during light sleep, a combined request, and a light-sleep write made during deep sleep. Each vector checks all five mode outputs, which tells apart the running state, light sleep and deep sleep, and shows whether a stimulus was ignored. Directed runs then measure the tick period in the running state and in light sleep. They also measure the exact edge count from wake to core enable and to the first warm-up tick, which separates an off-by-one in the prescaler from one in the startup counter. Further runs cover a reset taken in deep sleep and in warm-up, and a second instance built without deep sleep that receives both a lone deep-sleep request and a combined request.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_HALT = 2'd2,
    PM_WARM = 2'd3
  } pm_state_e;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pmc_prescaler.sv
module pmc_prescaler #(
  parameter int DIV_RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);

  localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (hold || at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = at_last && !hold;

endmodule

// File: rtl/pmc_startup_timer.sv
module pmc_startup_timer #(
  parameter int STARTUP_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic done
);

  localparam int CNT_W = $clog2(STARTUP_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STARTUP_TICKS);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (step && (cnt_q != '0));

  always_comb begin
    if (load) begin
      cnt_d = LOAD_VAL;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = step && !load && (cnt_q == ONE);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter bit HALT_ENABLE = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_we,
  input  logic      ctl_halt,
  input  logic      ctl_idle,
  input  logic      wake,
  input  logic      warm_done,
  output pm_state_e state
);

  pm_state_e state_q;
  pm_state_e state_d;
  logic      halt_req;
  logic      idle_req;

  generate
    if (HALT_ENABLE) begin : g_halt_on
      assign halt_req = ctl_we && ctl_halt;
    end else begin : g_halt_off
      logic halt_unused;
      assign halt_unused = ctl_halt;
      assign halt_req    = 1'b0;
    end
  endgenerate

  assign idle_req = ctl_we && ctl_idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (halt_req) begin
          state_d = PM_HALT;
        end else if (idle_req) begin
          state_d = PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (wake) begin
          state_d = PM_RUN;
        end
      end
      PM_HALT: begin
        if (wake) begin
          state_d = PM_WARM;
        end
      end
      PM_WARM: begin
        if (warm_done) begin
          state_d = PM_RUN;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int DIV_RATIO     = 10,
  parameter int STARTUP_TICKS = 256,
  parameter bit HALT_ENABLE   = 1'b1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_halt,
  input  logic ctl_idle,
  input  logic wake,
  output logic osc_en,
  output logic core_clk_en,
  output logic t0_clk_en,
  output logic tc_tick,
  output logic halt_flag,
  output logic idle_flag
);

  pm_state_e state;
  logic      rst_n_int;
  logic      pre_hold;
  logic      pre_tick;
  logic      warm_load;
  logic      warm_done;

  pmc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pmc_mode_fsm #(
    .HALT_ENABLE (HALT_ENABLE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ctl_we    (ctl_we),
    .ctl_halt  (ctl_halt),
    .ctl_idle  (ctl_idle),
    .wake      (wake),
    .warm_done (warm_done),
    .state     (state)
  );

  assign pre_hold  = (state == PM_HALT);
  assign warm_load = (state != PM_WARM);

  pmc_prescaler #(
    .DIV_RATIO (DIV_RATIO)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n_int),
    .hold  (pre_hold),
    .tick  (pre_tick)
  );

  pmc_startup_timer #(
    .STARTUP_TICKS (STARTUP_TICKS)
  ) u_startup (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (warm_load),
    .step  (pre_tick),
    .done  (warm_done)
  );

  always_comb begin
    osc_en      = 1'b1;
    core_clk_en = 1'b0;
    t0_clk_en   = 1'b0;
    halt_flag   = 1'b0;
    idle_flag   = 1'b0;
    unique case (state)
      PM_RUN: begin
        core_clk_en = 1'b1;
        t0_clk_en   = 1'b1;
      end
      PM_IDLE: begin
        t0_clk_en = 1'b1;
        idle_flag = 1'b1;
      end
      PM_HALT: begin
        osc_en    = 1'b0;
        halt_flag = 1'b1;
      end
      PM_WARM: begin
        halt_flag = 1'b1;
      end
      default: begin
        core_clk_en = 1'b1;
        t0_clk_en   = 1'b1;
      end
    endcase
  end

  assign tc_tick = pre_tick;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter bit HALT_ENABLE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_we,
  input logic ctl_halt,
  input logic ctl_idle,
  input logic wake,
  input logic osc_en,
  input logic core_clk_en,
  input logic t0_clk_en,
  input logic tc_tick,
  input logic halt_flag,
  input logic idle_flag
);

  logic req_any;
  assign req_any = ctl_we && (ctl_halt || ctl_idle);

  assert_halt_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_flag |-> (!core_clk_en && !t0_clk_en));

  assert_halt_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && !osc_en) |-> !tc_tick);

  assert_idle_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> (osc_en && t0_clk_en && !core_clk_en));

  assert_modes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_flag && idle_flag));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tc_tick |=> !tc_tick);

  assert_wake_osc_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && !osc_en && wake) |=> (osc_en && halt_flag && !core_clk_en && !t0_clk_en));

  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && wake) |=> (!idle_flag && core_clk_en));

  assert_run_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !req_any) |=> core_clk_en);

  assert_halt_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && !osc_en && !wake) |=> (halt_flag && !osc_en));

  always_comb begin
    if (!HALT_ENABLE) begin
      assert_no_halt_R10: assert (!halt_flag || !rst_n);
    end
  end

endmodule

bind pmc_power_ctrl pmc_checker #(
  .HALT_ENABLE (HALT_ENABLE)
) u_pmc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_we      (ctl_we),
  .ctl_halt    (ctl_halt),
  .ctl_idle    (ctl_idle),
  .wake        (wake),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .t0_clk_en   (t0_clk_en),
  .tc_tick     (tc_tick),
  .halt_flag   (halt_flag),
  .idle_flag   (idle_flag)
);

// File: tb/tb_pmc_power_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_power_ctrl;

  localparam int DIV    = 10;
  localparam int TICKS  = 256;
  localparam int WARM_T = DIV * TICKS;
  localparam int NVEC   = 8;

  // [8]we [7]halt [6]idle [5]wake | expected [4]core [3]osc [2]t0 [1]halt_flag [0]idle_flag
  localparam logic [8:0] VEC [NVEC] = '{
    {4'b0000, 5'b11100},   // R1 idle cycle in run
    {4'b0001, 5'b11100},   // R9 wake in run ignored
    {4'b1000, 5'b11100},   // R9 empty write ignored
    {4'b1010, 5'b01101},   // R4 enter light sleep
    {4'b1100, 5'b01101},   // R9 halt write in light sleep ignored
    {4'b0001, 5'b11100},   // R8 wake from light sleep
    {4'b1110, 5'b00010},   // R5 both bits -> deep sleep
    {4'b1010, 5'b00010}    // R9 idle write in deep sleep ignored
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_we, ctl_halt, ctl_idle, wake;
  logic osc_en, core_clk_en, t0_clk_en, tc_tick, halt_flag, idle_flag;
  logic nh_we, nh_halt, nh_idle, nh_wake;
  logic nh_osc, nh_core, nh_t0, nh_tick, nh_hflag, nh_iflag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pmc_power_ctrl #(.DIV_RATIO(DIV), .STARTUP_TICKS(TICKS), .HALT_ENABLE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_halt(ctl_halt), .ctl_idle(ctl_idle),
    .wake(wake), .osc_en(osc_en), .core_clk_en(core_clk_en), .t0_clk_en(t0_clk_en),
    .tc_tick(tc_tick), .halt_flag(halt_flag), .idle_flag(idle_flag));

  pmc_power_ctrl #(.DIV_RATIO(DIV), .STARTUP_TICKS(TICKS), .HALT_ENABLE(1'b0)) dut_nohalt (
    .clk(clk), .rst_n(rst_n), .ctl_we(nh_we), .ctl_halt(nh_halt), .ctl_idle(nh_idle),
    .wake(nh_wake), .osc_en(nh_osc), .core_clk_en(nh_core), .t0_clk_en(nh_t0),
    .tc_tick(nh_tick), .halt_flag(nh_hflag), .idle_flag(nh_iflag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {core_clk_en, osc_en, t0_clk_en, halt_flag, idle_flag};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int n;
    int gap;
    ctl_we = 0; ctl_halt = 0; ctl_idle = 0; wake = 0;
    nh_we = 0; nh_halt = 0; nh_idle = 0; nh_wake = 0;
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 during reset", 32'(outs()), 32'(5'b11100));
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 after release", 32'(outs()), 32'(5'b11100));

    // R2: tick period in run
    n = 0;
    while (!tc_tick && n < 3 * DIV) begin step(); n++; end
    gap = 0;
    do begin step(); gap++; end while (!tc_tick && gap < 3 * DIV);
    check("R2 run tick period", 32'(gap), 32'(DIV));

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      {ctl_we, ctl_halt, ctl_idle, wake} = VEC[i][8:5];
      step();
      check($sformatf("R3/R4/R5/R8/R9 vector %0d", i), 32'(outs()), 32'(VEC[i][4:0]));
    end
    ctl_we = 0; ctl_halt = 0; ctl_idle = 0; wake = 0;

    // R3: no tick in deep sleep
    n = 0;
    for (int i = 0; i < 2 * DIV; i++) begin step(); n += int'(tc_tick); end
    check("R3 no tick in deep sleep", 32'(n), 32'd0);
    check("R3 deep sleep outputs", 32'(outs()), 32'(5'b00010));

    // R6/R7: wake from deep sleep, measure timing
    wake = 1'b1;
    step();
    wake = 1'b0;
    check("R6 warm-up outputs", 32'(outs()), 32'(5'b01010));
    begin
      int first_tick = -1;
      int core_at = -1;
      for (int k = 0; k <= WARM_T + 5; k++) begin
        if (k > 0) step();
        if (tc_tick && first_tick < 0) first_tick = k;
        if (core_clk_en && core_at < 0) core_at = k;
        if (k == 20 && first_tick >= 0) begin
          ctl_we = 1; ctl_idle = 1;
        end
        if (k == 21) begin
          ctl_we = 0; ctl_idle = 0;
          check("R9 write in warm-up ignored", 32'(outs()), 32'(5'b01010));
        end
      end
      check("R7 first warm-up tick", 32'(first_tick), 32'(DIV - 1));
      check("R6 edges to core enable", 32'(core_at), 32'(WARM_T));
    end
    check("R6 run after warm-up", 32'(outs()), 32'(5'b11100));

    // R4: ticks continue in light sleep
    ctl_we = 1; ctl_idle = 1;
    step();
    ctl_we = 0; ctl_idle = 0;
    n = 0;
    for (int i = 0; i < 2 * DIV; i++) begin step(); n += int'(tc_tick); end
    check("R4 ticks in light sleep", 32'(n), 32'd2);
    wake = 1; step(); wake = 0;
    check("R8 back to run", 32'(outs()), 32'(5'b11100));

    // R11: reset in deep sleep
    ctl_we = 1; ctl_halt = 1; step(); ctl_we = 0; ctl_halt = 0;
    check("R11 in deep sleep", 32'(outs()), 32'(5'b00010));
    rst_n = 0; step();
    check("R11 reset exits deep sleep", 32'(outs()), 32'(5'b11100));
    rst_n = 1; repeat (3) step();
    check("R11 run after reset", 32'(outs()), 32'(5'b11100));

    // R11: reset in warm-up
    ctl_we = 1; ctl_halt = 1; step(); ctl_we = 0; ctl_halt = 0;
    wake = 1; step(); wake = 0;
    repeat (30) step();
    check("R11 in warm-up", 32'(outs()), 32'(5'b01010));
    rst_n = 0; step();
    check("R11 reset exits warm-up", 32'(outs()), 32'(5'b11100));
    rst_n = 1; repeat (3) step();

    // R10: deep sleep disabled build
    nh_we = 1; nh_halt = 1; step(); nh_we = 0; nh_halt = 0;
    check("R10 halt request ignored", 32'({nh_core, nh_osc, nh_t0, nh_hflag, nh_iflag}), 32'(5'b11100));
    nh_we = 1; nh_halt = 1; nh_idle = 1; step(); nh_we = 0; nh_halt = 0; nh_idle = 0;
    check("R10 both bits -> light sleep", 32'({nh_core, nh_osc, nh_t0, nh_hflag, nh_iflag}), 32'(5'b01101));
    nh_wake = 1; step(); nh_wake = 0;
    check("R10 wake returns to run", 32'({nh_core, nh_osc, nh_t0, nh_hflag, nh_iflag}), 32'(5'b11100));

    finish_run();
  end

endmodule